// File: doc/BRIEF.md
# Interrupt Entry Sequencer

The sequencer holds the pending flags of three asynchronous interrupt sources (external, performance monitor and decrementer), one flag per source. While the external-enable bit of the machine-state word is set, it takes the highest-priority pending source on a clock edge. On that edge it produces, all at once, everything a core needs to enter the handler: the return address to save, the state word to save, the replacement state word and the handler address. In the same edge it clears the flag of the source it took.

The core presents its next-PC and current machine-state word every cycle. Sources raise their flags through one-cycle request pulses. One registered strobe tells the core that an entry happened and which source caused it. The saved and new state words are computed with fixed masks: the interrupt-endian bit is copied into the little-endian bit, and the enable, translation and related control bits are cleared. The entry itself therefore turns off further interrupts once the core writes the new state back.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pending_o`, `taken_o`, `cause_o`, `save_pc_o`, `save_msr_o`, `new_msr_o` and `vector_o` are all zero.
- R2: A pulse on `raise_i[k]` sets `pending_o[k]` on the next cycle (bit 0 external, bit 1 performance monitor, bit 2 decrementer). While `msr_i[15]` is 0, no entry is taken, `taken_o` stays 0 and the pending flags are held.
- R3: When `msr_i[15]` is 1 and several flags are pending, the external source is taken before the performance monitor, and the performance monitor before the decrementer. `cause_o` reports 1 for external, 2 for performance monitor and 3 for decrementer.
- R4: An entry raises `taken_o` for the cycle after the deciding edge. Only the taken source's pending bit is cleared, so one source is handled per entry.
- R5: On entry `save_pc_o` equals the `npc_i` that was present at the deciding edge.
- R6: On entry `save_msr_o` equals that cycle's `msr_i` ANDed with 0x87C0FFFF.
- R7: On entry `new_msr_o` equals `msr_i` with bit 16 ORed into bit 0, then ANDed with the complement of 0x0004EF36.
- R8: On entry `vector_o` is 0x80000500 for external, 0x80000F00 for performance monitor and 0x80000900 for decrementer.
- R9: A request pulse on a source in the same cycle that source is taken leaves its pending bit set afterwards.
- R10: While no entry is taken, `save_pc_o`, `save_msr_o`, `new_msr_o`, `vector_o` and `cause_o` keep the values of the last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_i | input | 3 | Per-source request pulses (0 ext, 1 perf-mon, 2 decrementer) |
| npc_i | input | 32 | Next-PC of the core |
| msr_i | input | 32 | Current machine-state word |
| pending_o | output | 3 | Pending flags |
| taken_o | output | 1 | One-cycle entry strobe |
| cause_o | output | 2 | Code of the taken source |
| save_pc_o | output | 32 | Return address to save |
| save_msr_o | output | 32 | Machine-state word to save |
| new_msr_o | output | 32 | Machine-state word for the handler |
| vector_o | output | 32 | Handler address |

## Verification
The bench builds the block with its defaults: three sources and 32-bit addresses. With three sources the pending set has only seven non-empty masks, so every mask is swept against several state words. The state words include ones where the interrupt-endian bit is set or clear, and others that fill or empty the masked fields. For each mask the bench drains every flag and checks the order against the priority rule, so every cause, vector and mask path is reached. Two directed cases cover a hold with interrupts disabled and a re-raise that collides with a take.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int NUM_SRC  = 3;
    localparam int MSR_W    = 32;
    localparam int CAUSE_W  = 2;
    localparam int EE_BIT   = 15;
    localparam int ILE_BIT  = 16;
    localparam int LE_BIT   = 0;

    localparam logic [MSR_W-1:0] SAVE_KEEP_MASK = 32'h87C0_FFFF;
    localparam logic [MSR_W-1:0] ENTRY_CLR_MASK = 32'h0004_EF36;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_EXT  = 2'd1,
        CAUSE_PMON = 2'd2,
        CAUSE_DEC  = 2'd3
    } irq_cause_e;

    typedef struct packed {
        logic [MSR_W-1:0] saved;
        logic [MSR_W-1:0] next;
    } msr_pair_t;

    function automatic msr_pair_t entry_msr(input logic [MSR_W-1:0] cur);
        msr_pair_t r;
        logic [MSR_W-1:0] tmp;
        r.saved = cur & SAVE_KEEP_MASK;
        tmp = cur;
        tmp[LE_BIT] = cur[LE_BIT] | cur[ILE_BIT];
        r.next = tmp & ~ENTRY_CLR_MASK;
        return r;
    endfunction

endpackage

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raise,
    input  logic [N-1:0] clear,
    output logic [N-1:0] pend
);
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clear) | raise;
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    input  logic         enable,
    output logic [N-1:0] grant
);
    logic [N-1:0] gated;
    assign gated = enable ? req : '0;

    for (genvar i = 0; i < N; i++) begin : g_pick
        if (i == 0) begin : g_top
            assign grant[i] = gated[i];
        end else begin : g_rest
            assign grant[i] = gated[i] & ~(|gated[i-1:0]);
        end
    end
endmodule

// File: rtl/irq_entry_calc.sv
module irq_entry_calc
    import irq_entry_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_EXT  = 32'h8000_0500,
    parameter logic [ADDR_W-1:0] VEC_PMON = 32'h8000_0F00,
    parameter logic [ADDR_W-1:0] VEC_DEC  = 32'h8000_0900
) (
    input  logic [NUM_SRC-1:0] grant,
    input  logic [MSR_W-1:0]   msr,
    output irq_cause_e         cause,
    output logic [ADDR_W-1:0]  vector,
    output msr_pair_t          msr_out
);
    localparam logic [NUM_SRC-1:0][ADDR_W-1:0] VEC_TAB = {VEC_DEC, VEC_PMON, VEC_EXT};

    always_comb begin
        cause  = CAUSE_NONE;
        vector = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) begin
                cause  = irq_cause_e'(CAUSE_W'(i + 1));
                vector = vector | VEC_TAB[i];
            end
        end
    end

    assign msr_out = entry_msr(msr);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   raise_i,
    input  logic [ADDR_W-1:0]    npc_i,
    input  logic [MSR_W-1:0]     msr_i,
    output logic [NUM_SRC-1:0]   pending_o,
    output logic                 taken_o,
    output logic [CAUSE_W-1:0]   cause_o,
    output logic [ADDR_W-1:0]    save_pc_o,
    output logic [MSR_W-1:0]     save_msr_o,
    output logic [MSR_W-1:0]     new_msr_o,
    output logic [ADDR_W-1:0]    vector_o
);
    typedef struct packed {
        irq_cause_e        cause;
        logic [ADDR_W-1:0] pc;
        msr_pair_t         msr;
        logic [ADDR_W-1:0] vec;
    } entry_t;

    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] grant;
    irq_cause_e         cause_c;
    logic [ADDR_W-1:0]  vec_c;
    msr_pair_t          msr_c;
    entry_t             entry_q;
    logic               taken_q;

    irq_pending_reg #(.N(NUM_SRC)) u_pend (
        .clk   (clk),
        .rst   (rst),
        .raise (raise_i),
        .clear (grant),
        .pend  (pend_q)
    );

    irq_prio_pick #(.N(NUM_SRC)) u_pick (
        .req    (pend_q),
        .enable (msr_i[EE_BIT]),
        .grant  (grant)
    );

    irq_entry_calc #(
        .ADDR_W   (ADDR_W),
        .VEC_EXT  (ADDR_W'(32'h8000_0500)),
        .VEC_PMON (ADDR_W'(32'h8000_0F00)),
        .VEC_DEC  (ADDR_W'(32'h8000_0900))
    ) u_calc (
        .grant   (grant),
        .msr     (msr_i),
        .cause   (cause_c),
        .vector  (vec_c),
        .msr_out (msr_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_q <= 1'b0;
            entry_q <= '0;
        end else begin
            taken_q <= |grant;
            if (|grant) begin
                entry_q.cause <= cause_c;
                entry_q.pc    <= npc_i;
                entry_q.msr   <= msr_c;
                entry_q.vec   <= vec_c;
            end
        end
    end

    assign pending_o  = pend_q;
    assign taken_o    = taken_q;
    assign cause_o    = entry_q.cause;
    assign save_pc_o  = entry_q.pc;
    assign save_msr_o = entry_q.msr.saved;
    assign new_msr_o  = entry_q.msr.next;
    assign vector_o   = entry_q.vec;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk
    import irq_entry_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_SRC-1:0]   raise_i,
    input logic [ADDR_W-1:0]    npc_i,
    input logic [MSR_W-1:0]     msr_i,
    input logic [NUM_SRC-1:0]   pending_o,
    input logic                 taken_o,
    input logic [CAUSE_W-1:0]   cause_o,
    input logic [ADDR_W-1:0]    save_pc_o,
    input logic [MSR_W-1:0]     save_msr_o,
    input logic [ADDR_W-1:0]    vector_o
);
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !msr_i[EE_BIT] |=> !taken_o && pending_o == ($past(pending_o) | $past(raise_i))); // R2
    AST_DEC_LAST: assert property (@(posedge clk) disable iff (rst)
        taken_o && cause_o == 2'd3 |-> !$past(pending_o[0]) && !$past(pending_o[1])); // R3
    AST_PMON_AFTER_EXT: assert property (@(posedge clk) disable iff (rst)
        taken_o && cause_o == 2'd2 |-> !$past(pending_o[0])); // R3
    AST_TAKEN_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> cause_o != 2'd0 && $past(msr_i[EE_BIT])); // R4
    AST_PMON_CLEARED: assert property (@(posedge clk) disable iff (rst)
        taken_o && cause_o == 2'd2 |-> !pending_o[1] || $past(raise_i[1])); // R4
    AST_SAVE_PC: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> save_pc_o == $past(npc_i)); // R5
    AST_SAVE_MSR: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> save_msr_o == ($past(msr_i) & 32'h87C0_FFFF)); // R6
    AST_PMON_VECTOR: assert property (@(posedge clk) disable iff (rst)
        taken_o && cause_o == 2'd2 |-> vector_o == ADDR_W'(32'h8000_0F00)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !taken_o && !$past(rst) |-> $stable(save_pc_o) && $stable(vector_o)); // R10
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .raise_i    (raise_i),
    .npc_i      (npc_i),
    .msr_i      (msr_i),
    .pending_o  (pending_o),
    .taken_o    (taken_o),
    .cause_o    (cause_o),
    .save_pc_o  (save_pc_o),
    .save_msr_o (save_msr_o),
    .vector_o   (vector_o)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  raise_i;
    logic [31:0] npc_i;
    logic [31:0] msr_i;
    logic [2:0]  pending_o;
    logic        taken_o;
    logic [1:0]  cause_o;
    logic [31:0] save_pc_o, save_msr_o, new_msr_o, vector_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_entry_seq u_dut (
        .clk(clk), .rst(rst), .raise_i(raise_i), .npc_i(npc_i), .msr_i(msr_i),
        .pending_o(pending_o), .taken_o(taken_o), .cause_o(cause_o),
        .save_pc_o(save_pc_o), .save_msr_o(save_msr_o), .new_msr_o(new_msr_o),
        .vector_o(vector_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [31:0] exp_save(input logic [31:0] m);
        return m & 32'h87C0FFFF;
    endfunction

    function automatic logic [31:0] exp_new(input logic [31:0] m);
        return (m | ((m >> 16) & 32'h1)) & ~32'h0004EF36;
    endfunction

    function automatic logic [31:0] exp_vec(input int c);
        case (c)
            1: return 32'h80000500;
            2: return 32'h80000F00;
            3: return 32'h80000900;
            default: return 32'h0;
        endcase
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'hFFFFFFFF;
        pats[1] = 32'h00018000;
        pats[2] = 32'h5A3C8001;
        pats[3] = 32'h0000FFFE;
        rst = 1'b1; raise_i = '0; npc_i = '0; msr_i = '0;
        tick(); tick();
        chk("R1 pending", 32'(pending_o), 0);
        chk("R1 taken", 32'(taken_o), 0);
        chk("R1 vector", vector_o, 0);
        chk("R1 save_msr", save_msr_o, 0);
        rst = 1'b0;
        tick();
        chk("R1 after release", 32'(taken_o) | 32'(cause_o) | save_pc_o | new_msr_o, 0);

        for (int mask = 1; mask < 8; mask++) begin
            for (int p = 0; p < 4; p++) begin
                logic [2:0] left;
                msr_i   = pats[p] & ~32'h8000;
                raise_i = 3'(mask);
                tick();
                raise_i = '0;
                chk("R2 set", 32'(pending_o), 32'(mask));
                tick(); tick();
                chk("R2 held", 32'(pending_o), 32'(mask));
                chk("R2 no take", 32'(taken_o), 0);
                left = 3'(mask);
                while (left != 0) begin
                    int exp_c;
                    logic [31:0] m, pc;
                    exp_c = left[0] ? 1 : (left[1] ? 2 : 3);
                    m  = pats[p] | 32'h8000;
                    pc = 32'h1000 + 32'(mask * 64 + p * 8 + exp_c);
                    msr_i = m; npc_i = pc;
                    tick();
                    left[exp_c-1] = 1'b0;
                    chk("R4 taken", 32'(taken_o), 1);
                    chk("R3 cause", 32'(cause_o), 32'(exp_c));
                    chk("R4 pending", 32'(pending_o), 32'(left));
                    chk("R5 save_pc", save_pc_o, pc);
                    chk("R6 save_msr", save_msr_o, exp_save(m));
                    chk("R7 new_msr", new_msr_o, exp_new(m));
                    chk("R8 vector", vector_o, exp_vec(exp_c));
                    msr_i = 32'h0; npc_i = 32'hDEAD0000;
                    tick();
                    chk("R4 strobe single", 32'(taken_o), 0);
                    chk("R10 hold pc", save_pc_o, pc);
                    chk("R10 hold vec", vector_o, exp_vec(exp_c));
                end
            end
        end

        msr_i = 32'h8000;
        raise_i = 3'b010;
        tick();
        chk("R9 pmon pending", 32'(pending_o), 32'b010);
        raise_i = 3'b010;
        tick();
        raise_i = '0;
        msr_i = 32'h0;
        chk("R9 taken", 32'(cause_o), 2);
        chk("R9 kept", 32'(pending_o), 32'b010);
        msr_i = 32'h8000;
        tick();
        msr_i = 32'h0;
        chk("R9 drained", 32'(pending_o), 0);
        tick();
        chk("R4 idle", 32'(taken_o), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule